// File: doc/BRIEF.md
# Pseudo-Random Density Modulator

This block turns a programmable density value into a one-bit dimming stream. A free-running linear feedback shift register walks through every nonzero value of the selected width in a scrambled order. On each clock the current value is compared with the density, and the output is high whenever the value does not exceed it. Over one full sequence the output is high for as many clocks as the density says. Those high clocks are scattered through the sequence instead of forming one contiguous pulse. This spreads the switching energy across frequency and lowers emitted interference compared with a ramp-based pulse-width modulator.

The resolution runs from 1 to 16 bits and is picked with a 4-bit select that holds the width minus one. A sequence at width N lasts 2^N-1 clocks. The density arrives through a simple write strobe into a pending register. Both the pending density and the width select take effect only at the point where the sequence returns to its start. A sequence therefore never mixes two settings. Dropping the enable forces the output low and parks the generator at its start value, so the next enable begins a clean sequence.

Top module: `scatter_dimmer`

## Requirements
- R1: During and directly after synchronous reset, `mod_out` is 0, the pending density is 0 and the active width is 1 bit.
- R2: While `enable` is low, `mod_out` is 0 on every clock, whatever the density, and the generator returns to its start value of 1.
- R3: At width N (N = `width_sel`+1), over any one full sequence of 2^N-1 consecutive enabled clocks, the number of clocks with `mod_out` high equals the active density D (0 <= D <= 2^N-1).
- R4: Density bits at and above position N are ignored. Only `dens_wdata[N-1:0]` takes part in the compare.
- R5: A density of all ones at the active width keeps `mod_out` high for the whole sequence. A density of 0 keeps it low.
- R6: A density written during a sequence does not affect that sequence's output. It takes effect from the first clock of the next sequence.
- R7: A change of `width_sel` during a sequence does not affect that sequence's length. The new width applies from the next sequence.
- R8: The generator state is never zero and never has bits set above the active width. The sequence at width N has period 2^N-1.
- R9: The high clocks are scattered. At width 8 with density 127, no run of consecutive high outputs within a sequence is longer than 16 clocks.
- R10: After `enable` returns high, the first full sequence already produces the R3 count for the current density.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the modulator; low forces output low and restarts the sequence |
| width_sel | input | 4 | Resolution minus one (0 = 1 bit, 15 = 16 bits), taken at sequence start |
| dens_we | input | 1 | Write strobe for the density register |
| dens_wdata | input | 16 | Density value to write |
| mod_out | output | 1 | Registered modulated output |

## Verification
The bound checker watches, on every cycle, that the output stays low after a disabled clock and that the generator state is nonzero and fits the active width. It also checks that the active settings change only while the generator sits at its start value, and that all-ones and zero densities force the output level. The exact high-clock count per sequence, the scattering of those clocks, and the deferral of writes and width changes across a running sequence can only be seen over whole sequences. The bench covers these by sweeping every density at widths 1 to 6, adding single sequences at widths 8, 10, 12 and 16, and changing settings mid-sequence.

// File: rtl/sdim_pkg.sv
package sdim_pkg;

    localparam int MAX_W = 16;
    localparam int SEL_W = $clog2(MAX_W);

    typedef logic [MAX_W-1:0] word_t;
    typedef logic [SEL_W-1:0] wsel_t;

    // Settings in force for the current sequence
    typedef struct packed {
        wsel_t wsel;
        word_t density;
    } cfg_t;

    localparam word_t SEED = word_t'(1);

    // Feedback taps of a maximal-length sequence per width (bit t-1 set for tap t)
    function automatic word_t tap_mask(input wsel_t wsel);
        word_t m;
        case (wsel)
            4'd0:    m = 16'h0001;
            4'd1:    m = 16'h0003;
            4'd2:    m = 16'h0006;
            4'd3:    m = 16'h000C;
            4'd4:    m = 16'h0014;
            4'd5:    m = 16'h0030;
            4'd6:    m = 16'h0060;
            4'd7:    m = 16'h00B8;
            4'd8:    m = 16'h0110;
            4'd9:    m = 16'h0240;
            4'd10:   m = 16'h0500;
            4'd11:   m = 16'h0829;
            4'd12:   m = 16'h100D;
            4'd13:   m = 16'h2015;
            4'd14:   m = 16'h6000;
            default: m = 16'hD008;
        endcase
        return m;
    endfunction

    // Ones in the low (wsel+1) bits
    function automatic word_t width_mask(input wsel_t wsel);
        logic [MAX_W:0] t;
        t = (( (MAX_W+1)'(1) ) << (int'(wsel) + 1)) - (MAX_W+1)'(1);
        return t[MAX_W-1:0];
    endfunction

endpackage

// File: rtl/sdim_lfsr.sv
module sdim_lfsr
    import sdim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  word_t taps,
    input  word_t wmask,
    output word_t state,
    output logic  at_last
);

    word_t state_q;
    word_t next_s;
    logic  fb;

    always_comb begin
        fb     = ^(state_q & taps);
        next_s = ({state_q[MAX_W-2:0], fb}) & wmask;
    end

    // The current value is the last of its sequence when the next one is the start
    assign at_last = run && (next_s == SEED);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state_q <= SEED;
        end else begin
            state_q <= next_s;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/sdim_cfg.sv
module sdim_cfg
    import sdim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  reload,
    input  logic  wr_en,
    input  word_t wr_data,
    input  wsel_t wsel_in,
    output word_t dens_eff,
    output word_t wmask,
    output word_t taps
);

    word_t pend_q;
    cfg_t  act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (wr_en) begin
            pend_q <= wr_data;
        end
    end

    // Settings change only where a new sequence starts, or while parked
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '{wsel: '0, density: '0};
        end else if (!run || reload) begin
            act_q <= '{wsel: wsel_in, density: pend_q};
        end
    end

    always_comb begin
        wmask    = width_mask(act_q.wsel);
        taps     = tap_mask(act_q.wsel);
        dens_eff = act_q.density & wmask;
    end

endmodule

// File: rtl/sdim_cmp.sv
module sdim_cmp
    import sdim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  word_t value,
    input  word_t level,
    output logic  hit
);

    logic hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= run && (value <= level);
        end
    end

    assign hit = hit_q;

endmodule

// File: rtl/scatter_dimmer.sv
module scatter_dimmer
    import sdim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [SEL_W-1:0]      width_sel,
    input  logic                  dens_we,
    input  logic [MAX_W-1:0]      dens_wdata,
    output logic                  mod_out
);

    word_t lfsr_q;
    word_t dens_eff;
    word_t wmask_act;
    word_t taps_act;
    logic  seq_last;

    sdim_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .run      (enable),
        .reload   (seq_last),
        .wr_en    (dens_we),
        .wr_data  (dens_wdata),
        .wsel_in  (width_sel),
        .dens_eff (dens_eff),
        .wmask    (wmask_act),
        .taps     (taps_act)
    );

    sdim_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .run     (enable),
        .taps    (taps_act),
        .wmask   (wmask_act),
        .state   (lfsr_q),
        .at_last (seq_last)
    );

    sdim_cmp u_cmp (
        .clk   (clk),
        .rst   (rst),
        .run   (enable),
        .value (lfsr_q),
        .level (dens_eff),
        .hit   (mod_out)
    );

endmodule

// File: rtl/scatter_dimmer_chk.sv
module scatter_dimmer_chk
    import sdim_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  enable,
    input logic  mod_out,
    input word_t lfsr_state,
    input word_t dens_eff,
    input word_t wmask
);

    // R2: a disabled clock leaves the output low on the next cycle
    p_low_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !mod_out);

    // R8: generator never reaches the all-zero state
    p_state_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    // R8: no state bits above the active width
    p_state_in_width_r8: assert property (@(posedge clk) disable iff (rst)
        (lfsr_state & ~wmask) == '0);

    // R6: active density moves only at a sequence start
    p_dens_at_start_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(dens_eff) |-> (lfsr_state == SEED));

    // R7: active width moves only at a sequence start
    p_width_at_start_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(wmask) |-> (lfsr_state == SEED));

    // R5: full-scale density drives the output high
    p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
        (enable && dens_eff == wmask) |=> mod_out);

    // R5: zero density keeps the output low
    p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
        (dens_eff == '0) |=> !mod_out);

endmodule

bind scatter_dimmer scatter_dimmer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .mod_out    (mod_out),
    .lfsr_state (lfsr_q),
    .dens_eff   (dens_eff),
    .wmask      (wmask_act)
);

// File: tb/scatter_dimmer_test.sv
`timescale 1ns/1ps
module scatter_dimmer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [3:0]  width_sel;
    logic        dens_we;
    logic [15:0] dens_wdata;
    logic        mod_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scatter_dimmer uut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .width_sel  (width_sel),
        .dens_we    (dens_we),
        .dens_wdata (dens_wdata),
        .mod_out    (mod_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Disable, write density, pick width, let one parked edge load it
    task automatic setup(input int w, input int d);
        @(negedge clk);
        enable     = 1'b0;
        dens_we    = 1'b1;
        dens_wdata = 16'(d);
        width_sel  = 4'(w - 1);
        @(negedge clk);
        dens_we = 1'b0;
        @(negedge clk);
    endtask

    // Sample p enabled outputs; return high count and longest high run
    task automatic run_seq(input int p, output int hi, output int maxrun);
        int run;
        hi = 0; maxrun = 0; run = 0;
        enable = 1'b1;
        for (int i = 0; i < p; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (mod_out) begin
                hi++; run++;
                if (run > maxrun) maxrun = run;
            end else begin
                run = 0;
            end
        end
    endtask

    initial begin
        int hi, mr, lows;
        rst = 1'b1; enable = 1'b0; width_sel = '0; dens_we = 1'b0; dens_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 out in reset", int'(mod_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out after reset", int'(mod_out), 0);
        // R1: pending density 0, width 1 -> one-clock sequence low
        run_seq(1, hi, mr);
        check("R1 reset density/width", hi, 0);

        // R2: disabled with full density stays low
        setup(8, 16'hFFFF);
        lows = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (!mod_out) lows++;
        end
        check("R2 low while disabled", lows, 20);

        // R3: exhaustive sweep, widths 1..6, every density
        for (int w = 1; w <= 6; w++) begin
            for (int d = 0; d < (1 << w); d++) begin
                setup(w, d);
                run_seq((1 << w) - 1, hi, mr);
                check($sformatf("R3 w=%0d d=%0d", w, d), hi, d);
            end
        end

        // R4: upper density bits ignored
        setup(4, 16'hABC3);
        run_seq(15, hi, mr);
        check("R4 w=4 upper bits", hi, 3);
        setup(10, 16'hFC00 | 517);
        run_seq(1023, hi, mr);
        check("R4 w=10 upper bits", hi, 517);

        // R5: full scale and zero at width 12
        setup(12, 16'h0FFF);
        run_seq(4095, hi, mr);
        check("R5 all ones constant high", mr, 4095);
        setup(12, 16'hF000);
        run_seq(4095, hi, mr);
        check("R5 zero constant low", hi, 0);

        // R9: scattering at width 8
        setup(8, 127);
        run_seq(255, hi, mr);
        check("R3 w=8 d=127", hi, 127);
        check("R9 longest run <= 16", int'(mr <= 16), 1);

        // R6 + R7: write density and width mid-sequence
        setup(3, 2);
        enable = 1'b1;
        hi = 0;
        for (int i = 0; i < 7; i++) begin
            @(posedge clk); @(negedge clk);
            if (mod_out) hi++;
            if (i == 1) begin dens_we = 1'b1; dens_wdata = 16'd9; width_sel = 4'd4; end
            if (i == 2) dens_we = 1'b0;
        end
        check("R6 old density kept", hi, 2);
        run_seq(31, hi, mr);
        check("R7 new width/density next sequence", hi, 9);
        run_seq(31, hi, mr);
        check("R7 sequence length 31", hi, 9);

        // R10: disable mid-sequence then restart
        setup(6, 40);
        run_seq(17, hi, mr);
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        run_seq(63, hi, mr);
        check("R10 restart full count", hi, 40);

        // R8: widest sequence, one period
        setup(16, 40000);
        run_seq(65535, hi, mr);
        check("R8 w=16 d=40000", hi, 40000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule